// File: doc/BRIEF.md
# Register-Driven MDIO Management Master

This block carries out clause 22 management transactions towards one PHY over a two-wire management bus (MDC clock, bidirectional MDIO data). Software controls it through a single 32-bit access word. The word holds a direction/completion flag, a 5-bit PHY register number and a 16-bit data field. Writing the word starts a frame. The polarity of the flag selects the operation. A 1 requests a register write, and the block drops the flag to 0 when the write frame has been sent. A 0 requests a register read, and the block raises the flag to 1 once the returned value has been stored in the data field.

Every frame goes to the same PHY address, 1. There is no way to change it at run time. MDC runs only while a frame is in flight, at a rate set by a divider parameter applied to the system clock. MDIO is split into an input, an output and an output enable, so that a pad or the test bench can resolve the shared wire.

Top module: `mdio_access_master`

## Requirements
- R1: After reset the access word reads 0x00000000, `mdc` is 0, `mdio_oe` is 0 and `mdio_o` is 1.
- R2: Writing the access word with bit 31 = 1 sends a 64-bit frame, most significant bit first, with `mdio_oe` high on every bit. The bits are 32 ones, start 01, opcode 01, PHY address 00001, register address (bits 20:16), turnaround 10 and the data field (bits 15:0).
- R3: During a write, bit 31 reads 1. After the last frame bit it reads 0, and bits 20:0 keep the written values.
- R4: Writing the access word with bit 31 = 0 sends 32 ones, start 01, opcode 10, PHY address 00001 and the register address, with `mdio_oe` high. `mdio_oe` is low for the remaining 18 bit times (turnaround and data).
- R5: During a read, bit 31 reads 0. On completion bit 31 reads 1 and bits 15:0 hold the 16 values of `mdio_i` sampled at the rising `mdc` edges of the last 16 bit times, first sample in bit 15.
- R6: Bits 30:21 always read 0, including after a write that sets them.
- R7: Each `mdc` period is 2*CLK_DIV system clocks. `mdio_o` changes only while `mdc` is low. `mdc` stays low while no frame is in flight.
- R8: A write to the access word while a frame is in flight has no effect. The word keeps its value, the frame carries on unchanged, and no further frame starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_wr_en | input | 1 | Write strobe for the access word |
| acc_wr_data | input | 32 | Value written to the access word |
| acc_rd_data | output | 32 | Current access word contents |
| mdc | output | 1 | Management clock |
| mdio_i | input | 1 | Management data from the wire |
| mdio_o | output | 1 | Management data driven onto the wire |
| mdio_oe | output | 1 | Drive enable for `mdio_o` |

## Verification
The hardest case to reach from the ports is a write to the access word that lands in the middle of a frame. It has to leave both the serial stream and the stored word untouched, and it must not start a second frame afterwards. The stimulus issues a competing command about a third of the way through a write frame, with a different opcode, address and data. The bench then checks the word in mid-flight, the bits captured on the wire and the number of MDC edges after the expected finish. A model of the PHY attached to MDC returns a different pattern for each read, so that bit order and capture timing are both exposed.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int unsigned PRE_LEN   = 32;
  localparam int unsigned REG_AW    = 5;
  localparam int unsigned DATA_W    = 16;
  localparam int unsigned FRAME_LEN = PRE_LEN + 2 + 2 + 5 + REG_AW + 2 + DATA_W;
  localparam int unsigned IDX_W     = $clog2(FRAME_LEN);
  // Bit time at which a read hands the wire to the PHY (turnaround start)
  localparam int unsigned TA_IDX    = PRE_LEN + 2 + 2 + 5 + REG_AW;
  localparam int unsigned DATA_IDX  = TA_IDX + 2;
  localparam logic [4:0]  PHY_ADDR_FIXED = 5'b00001;

  localparam int unsigned FLAG_BIT  = 31;
  localparam int unsigned RA_LSB    = 16;

  // Full serial frame, first bit at the MSB
  function automatic logic [FRAME_LEN-1:0] build_frame(
    input logic              rd,
    input logic [REG_AW-1:0] ra,
    input logic [DATA_W-1:0] wd
  );
    logic [1:0] op;
    logic [1:0] ta;
    op = rd ? 2'b10 : 2'b01;
    ta = rd ? 2'b11 : 2'b10;
    return {{PRE_LEN{1'b1}}, 2'b01, op, PHY_ADDR_FIXED, ra, ta,
            (rd ? {DATA_W{1'b1}} : wd)};
  endfunction

  // Whether the master drives the wire during a given bit time
  function automatic logic master_drives(input logic rd, input logic [IDX_W-1:0] idx);
    return !rd || (int'(idx) < TA_IDX);
  endfunction
endpackage

// File: rtl/mdio_clk_gen.sv
module mdio_clk_gen #(
  parameter int unsigned CLK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_evt,
  output logic fall_evt
);
  localparam int unsigned CNT_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CLK_DIV - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             half_end;

  assign half_end = run && (cnt_q == CNT_LAST);
  assign rise_evt = half_end && !mdc;
  assign fall_evt = half_end && mdc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc   <= 1'b0;
    end else if (!run) begin
      cnt_q <= '0;
      mdc   <= 1'b0;
    end else if (half_end) begin
      cnt_q <= '0;
      mdc   <= !mdc;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  p_evt_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rise_evt, fall_evt}));
  p_rise_from_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rise_evt |=> mdc);
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_rd,
  input  logic [REG_AW-1:0] start_ra,
  input  logic [DATA_W-1:0] start_wd,
  input  logic              rise_evt,
  input  logic              fall_evt,
  input  logic              mdio_i,
  output logic              busy,
  output logic              done,
  output logic              xfer_rd,
  output logic [DATA_W-1:0] rd_word,
  output logic              mdio_o,
  output logic              mdio_oe
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);

  logic [FRAME_LEN-1:0] frame_sr;
  logic [IDX_W-1:0]     bit_idx;
  logic [IDX_W-1:0]     next_idx;
  logic                 last_bit;
  logic                 capture_now;

  assign next_idx    = bit_idx + 1'b1;
  assign last_bit    = (bit_idx == LAST_IDX);
  assign done        = busy && fall_evt && last_bit;
  assign capture_now = busy && rise_evt && xfer_rd && (int'(bit_idx) >= DATA_IDX);
  assign mdio_o      = frame_sr[FRAME_LEN-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      xfer_rd  <= 1'b0;
      frame_sr <= '1;
      bit_idx  <= '0;
      mdio_oe  <= 1'b0;
      rd_word  <= '0;
    end else if (start) begin
      busy     <= 1'b1;
      xfer_rd  <= start_rd;
      frame_sr <= build_frame(start_rd, start_ra, start_wd);
      bit_idx  <= '0;
      mdio_oe  <= 1'b1;
      rd_word  <= '0;
    end else if (busy) begin
      if (capture_now) rd_word <= {rd_word[DATA_W-2:0], mdio_i};
      if (fall_evt) begin
        if (last_bit) begin
          busy     <= 1'b0;
          frame_sr <= '1;
          mdio_oe  <= 1'b0;
        end else begin
          bit_idx  <= next_idx;
          frame_sr <= {frame_sr[FRAME_LEN-2:0], 1'b1};
          mdio_oe  <= master_drives(xfer_rd, next_idx);
        end
      end
    end
  end

  p_ta_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy && xfer_rd && (int'(bit_idx) >= TA_IDX) |-> !mdio_oe);
  p_write_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !xfer_rd |-> mdio_oe);
  p_no_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start);
endmodule

// File: rtl/mdio_access_reg.sv
module mdio_access_reg
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [31:0]       wr_data,
  input  logic              busy,
  input  logic              done,
  input  logic              xfer_rd,
  input  logic [DATA_W-1:0] rd_word,
  output logic              start,
  output logic [31:0]       acc_q
);
  logic              flag_q;
  logic [REG_AW-1:0] ra_q;
  logic [DATA_W-1:0] data_q;

  assign start = wr_en && !busy;
  assign acc_q = {flag_q, {(31-RA_LSB-REG_AW){1'b0}}, ra_q, data_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      ra_q   <= '0;
      data_q <= '0;
    end else if (start) begin
      flag_q <= wr_data[FLAG_BIT];
      ra_q   <= wr_data[RA_LSB +: REG_AW];
      data_q <= wr_data[DATA_W-1:0];
    end else if (done) begin
      flag_q <= xfer_rd;
      if (xfer_rd) data_q <= rd_word;
    end
  end

  p_flag_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done && !xfer_rd |=> !acc_q[FLAG_BIT]);
  p_flag_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done && xfer_rd |=> acc_q[FLAG_BIT] && (acc_q[DATA_W-1:0] == $past(rd_word)));
  p_busy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !done |=> $stable(acc_q));
  p_resv_dropped_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start && (|wr_data[30:21]) |=> (acc_q[30:21] == '0));
endmodule

// File: rtl/mdio_access_master.sv
module mdio_access_master
  import mdio_pkg::*;
#(
  parameter int unsigned CLK_DIV = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acc_wr_en,
  input  logic [31:0] acc_wr_data,
  output logic [31:0] acc_rd_data,
  output logic        mdc,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe
);
  logic              start;
  logic              busy;
  logic              done;
  logic              xfer_rd;
  logic              rise_evt;
  logic              fall_evt;
  logic [DATA_W-1:0] rd_word;

  mdio_access_reg u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (acc_wr_en),
    .wr_data (acc_wr_data),
    .busy    (busy),
    .done    (done),
    .xfer_rd (xfer_rd),
    .rd_word (rd_word),
    .start   (start),
    .acc_q   (acc_rd_data)
  );

  mdio_clk_gen #(.CLK_DIV(CLK_DIV)) u_clk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (busy),
    .mdc      (mdc),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt)
  );

  mdio_frame_engine u_eng (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .start_rd (!acc_wr_data[FLAG_BIT]),
    .start_ra (acc_wr_data[RA_LSB +: REG_AW]),
    .start_wd (acc_wr_data[DATA_W-1:0]),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt),
    .mdio_i   (mdio_i),
    .busy     (busy),
    .done     (done),
    .xfer_rd  (xfer_rd),
    .rd_word  (rd_word),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe)
  );

  p_mdo_low_phase_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mdio_o) |-> !mdc);
  p_idle_mdc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);
endmodule

// File: tb/mdio_access_master_tb.sv
module mdio_access_master_tb_top;
  localparam int unsigned DIV      = 2;
  localparam int unsigned FRAME_CY = 64 * 2 * DIV;
  localparam int unsigned NVEC     = 6;
  // {is_read, reg addr, write data, PHY return value}
  localparam logic [37:0] VEC [NVEC] = '{
    {1'b0, 5'h00, 16'h1234, 16'h0000},
    {1'b1, 5'h02, 16'h0000, 16'hA5C3},
    {1'b0, 5'h1F, 16'hFFFF, 16'h0000},
    {1'b1, 5'h11, 16'hBEEF, 16'h0001},
    {1'b0, 5'h0A, 16'h8001, 16'h0000},
    {1'b1, 5'h1F, 16'h0000, 16'hFFFE}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_wr_en = 1'b0;
  logic [31:0] acc_wr_data = '0;
  logic [31:0] acc_rd_data;
  logic        mdc;
  logic        mdio_i = 1'b1;
  logic        mdio_o;
  logic        mdio_oe;

  int          n_checks = 0;
  int          n_errors = 0;
  bit          ended = 1'b0;

  int          rise_cnt = 0;
  logic [63:0] cap_o = '0;
  logic [63:0] cap_oe = '0;
  logic [15:0] phy_ret = '0;
  time         last_rise = 0;
  time         period = 0;
  int          hi_changes = 0;

  mdio_access_master #(.CLK_DIV(DIV)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_wr_en   (acc_wr_en),
    .acc_wr_data (acc_wr_data),
    .acc_rd_data (acc_rd_data),
    .mdc         (mdc),
    .mdio_i      (mdio_i),
    .mdio_o      (mdio_o),
    .mdio_oe     (mdio_oe)
  );

  always #4 clk = !clk;

  // PHY-side observer: records the wire at each rising MDC edge
  always begin
    @(posedge mdc);
    #1;
    if (rise_cnt < 64) begin
      cap_o[63-rise_cnt]  = mdio_o;
      cap_oe[63-rise_cnt] = mdio_oe;
    end
    if (last_rise != 0) period = $time - 1 - last_rise;
    last_rise = $time - 1;
    rise_cnt++;
  end

  // PHY-side driver: presents read data after each falling MDC edge
  always begin
    @(negedge mdc);
    #1;
    if (rise_cnt >= 48 && rise_cnt < 64) mdio_i = phy_ret[63-rise_cnt];
    else mdio_i = 1'b1;
  end

  always begin
    @(mdio_o);
    #1;
    if (mdc) hi_changes++;
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  endtask

  task automatic wait_cy(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic issue(input logic [31:0] w);
    @(negedge clk);
    acc_wr_data = w;
    acc_wr_en   = 1'b1;
    @(negedge clk);
    acc_wr_en   = 1'b0;
  endtask

  function automatic logic [63:0] exp_frame(input logic rd, input logic [4:0] ra, input logic [15:0] wd);
    return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), 5'b00001, ra,
            (rd ? 2'b00 : 2'b10), (rd ? 16'h0000 : wd)};
  endfunction

  function automatic logic [63:0] exp_oe(input logic rd);
    return rd ? {{46{1'b1}}, 18'b0} : {64{1'b1}};
  endfunction

  initial begin
    #(200000 * 8);
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R1 reset state
    wait_cy(3);
    rst_n = 1'b1;
    wait_cy(2);
    check("R1 word", 64'(acc_rd_data), 64'h0);
    check("R1 pins", 64'({mdc, mdio_oe, mdio_o}), 64'b001);

    // Vector table
    for (int i = 0; i < NVEC; i++) begin
      logic        rd;
      logic [4:0]  ra;
      logic [15:0] wd;
      logic [63:0] ef;
      logic [63:0] eo;
      {rd, ra, wd, phy_ret} = VEC[i];
      rise_cnt = 0;
      last_rise = 0;
      issue({!rd, 10'h0, ra, wd});
      wait_cy(FRAME_CY / 2);
      check(rd ? "R5 flag busy" : "R3 flag busy", 64'(acc_rd_data[31]), 64'(!rd));
      wait_cy(FRAME_CY / 2 + 8);
      ef = exp_frame(rd, ra, wd);
      eo = exp_oe(rd);
      if (rd) begin
        check("R4 oe", cap_oe, eo);
        check("R4 frame", cap_o & eo, ef & eo);
        check("R5 word", 64'(acc_rd_data), 64'({1'b1, 10'h0, ra, phy_ret}));
      end else begin
        check("R2 oe", cap_oe, eo);
        check("R2 frame", cap_o, ef);
        check("R3 word", 64'(acc_rd_data), 64'({1'b0, 10'h0, ra, wd}));
      end
      check("R7 period", 64'(period), 64'(2 * DIV * 8));
      check("R7 idle mdc", 64'(mdc), 64'h0);
    end

    // R8: competing command mid-frame
    rise_cnt = 0;
    issue({1'b1, 10'h0, 5'h03, 16'h5A5A});
    wait_cy(FRAME_CY / 3);
    issue({1'b0, 10'h0, 5'h07, 16'h0F0F});
    wait_cy(4);
    check("R8 word busy", 64'(acc_rd_data), 64'({1'b1, 10'h0, 5'h03, 16'h5A5A}));
    wait_cy(FRAME_CY);
    check("R8 word after", 64'(acc_rd_data), 64'({1'b0, 10'h0, 5'h03, 16'h5A5A}));
    check("R8 frame", cap_o, exp_frame(1'b0, 5'h03, 16'h5A5A));
    check("R8 edges", 64'(rise_cnt), 64'd64);

    // R6: reserved bits written as ones
    rise_cnt = 0;
    issue(32'hFFE0_1234);
    wait_cy(FRAME_CY + 8);
    check("R6 write resv", 64'(acc_rd_data), 64'h0000_1234);
    rise_cnt = 0;
    phy_ret = 16'h8421;
    issue(32'h7FE5_0000);
    wait_cy(FRAME_CY + 8);
    check("R6 read resv", 64'(acc_rd_data), 64'h8005_8421);
    check("R4 read addr", cap_o & exp_oe(1'b1), exp_frame(1'b1, 5'h05, 16'h0) & exp_oe(1'b1));

    check("R7 mdio_o high-phase changes", 64'(hi_changes), 64'h0);
    finish_run();
  end
endmodule